// File: doc/BRIEF.md
# Character-Synchronous Receiver with SYN Hunt

This block is the receive half of a character-oriented synchronous serial link that runs on a 1x bit clock. Each bit arrives on `rx_data` and is qualified by a one-cycle `rx_bit_en` strobe. When the receiver is switched on, it hunts bit by bit for a programmable sync character. In dual-sync mode it then requires a second programmable character. Once it holds character framing, it assembles characters of 5 to 8 data bits, sent least significant bit first, each optionally followed by a parity bit. It places them in a holding register and raises a ready flag.

The host programs the two sync patterns, the character length and the parity. It also selects single or dual sync, sync-character stripping, and an external-sync mode. In external-sync mode the internal pattern search is switched off, and a rising edge on `ext_sync` forces framing to start at the next received bit. A sticky sync-detect flag reports every sync event until the host strobes `stat_rd`. A separate `data_rd` strobe empties the holding register.

Top module: `bsync_rx`

## Requirements
- R1: After reset `hold_data` is 0, and `rx_ready`, `syn_det`, `parity_err` and `overrun_err` are 0.
- R2: Only a 0-to-1 change of `rx_enable` starts a hunt. While `rx_enable` is 0, bits are ignored. After `rx_enable` has been 0, a character that arrives after the next enable is not loaded until sync is found again.
- R3: During the hunt, the last L received bits are compared with SYN1 after every bit, where L = 5 + `char_len` (`char_len` 0..3 gives 5..8 bits; the first bit received is bit 0). A match in single-sync mode (`dbl_syn`=0) sets `syn_det`. The sync character is never loaded into the holding register.
- R4: In dual-sync mode (`dbl_syn`=1), sync is reached only when the full character after SYN1 equals SYN2. Any other character returns the receiver to the hunt, and no comparison is made on that bit, so SYN1-SYN1-SYN2 does not synchronise.
- R5: Once synchronised, every frame of L data bits (plus a parity bit when `parity_en`=1) loads the character into `hold_data` with its unused upper bits zero and sets `rx_ready`. `data_rd` clears `rx_ready`.
- R6: With `parity_en`=1, `parity_err` is loaded with each character. It is 1 when the count of ones over the data bits and the parity bit is odd with `parity_odd`=0, or even with `parity_odd`=1. The parity bit that follows a sync character during the hunt is skipped unchecked.
- R7: `overrun_err` is loaded with each character. It is 1 when `rx_ready` was still set and not being read in that cycle.
- R8: Once synchronised with `strip_en`=1, characters equal to SYN1, or to SYN2 in dual-sync mode, are not loaded. With `strip_en`=0 they are loaded. A later SYN1 (single-sync mode) or SYN1-SYN2 pair (dual-sync mode) sets `syn_det` again.
- R9: With `ext_mode`=1 the pattern search is disabled. A rising edge of `ext_sync` makes the next received bit data bit 0 of the first character, sets `syn_det`, and every later character is loaded without sync comparison.
- R10: `syn_det` stays 1 until `stat_rd` is pulsed; a sync event in the same cycle wins over the read.
- R11: Only the low L bits of SYN1 and SYN2 take part in any comparison; upper register bits have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_bit_en | input | 1 | One-cycle strobe per received bit (1x clock) |
| rx_data | input | 1 | Serial data, sampled when `rx_bit_en` is 1 |
| rx_enable | input | 1 | Receiver enable; a rising change starts a hunt |
| syn1 | input | 8 | First sync pattern |
| syn2 | input | 8 | Second sync pattern (dual-sync mode) |
| char_len | input | 2 | Data bits per character minus 5 |
| parity_en | input | 1 | A parity bit follows each character |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| dbl_syn | input | 1 | 1 = SYN1 then SYN2 required |
| strip_en | input | 1 | Drop sync characters after sync |
| ext_mode | input | 1 | External sync replaces pattern search |
| ext_sync | input | 1 | External sync input, rising-edge active |
| data_rd | input | 1 | Host read strobe for the holding register |
| stat_rd | input | 1 | Host read strobe for status; clears `syn_det` |
| hold_data | output | 8 | Received character, zero-extended |
| rx_ready | output | 1 | Holding register full |
| syn_det | output | 1 | Sticky sync-detect status |
| parity_err | output | 1 | Parity error of the held character |
| overrun_err | output | 1 | Held character overwrote an unread one |

## Verification
The table of vectors acquires sync and then receives one character, for each character length and parity setting, with correct and corrupted parity bits. Its SYN1 registers carry garbage upper bits, which separates length masking and frame counting from parity checking. Directed streams pit a correct SYN1-SYN2 pair against the SYN1-SYN1-SYN2 sequence, which exposes a receiver that keeps searching on the rejected bit. They also send a SYN1 while the enable is low, and a character after the enable is toggled, to check that only the rising change matters. Further streams send sync characters with stripping on and off, back-to-back characters without reads to produce an overrun, and an external pulse placed among a stream that contains SYN1. The last stream shows that the pulse sets the framing and that the pattern search is off.

// File: rtl/bsync_rx_pkg.sv
package bsync_rx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HUNT = 2'd1,
      ST_SYN2 = 2'd2,
      ST_SYNC = 2'd3
   } rx_state_e;
endpackage

// File: rtl/bsync_rx_shift.sv
module bsync_rx_shift #(
   parameter int W     = 8,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             clr,
   input  logic             din,
   output logic [W-1:0]     win_nxt,
   output logic [CNT_W-1:0] fill_nxt
);
   logic [W-1:0]     win_q;
   logic [CNT_W-1:0] fill_q;

   // newest bit enters at the top, so the oldest of the last L bits is bit W-L
   assign win_nxt  = {din, win_q[W-1:1]};
   assign fill_nxt = (fill_q == CNT_W'(W)) ? fill_q : fill_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q  <= '0;
         fill_q <= '0;
      end else if (clr) begin
         fill_q <= '0;
      end else if (shift_en) begin
         win_q  <= win_nxt;
         fill_q <= fill_nxt;
      end
   end
endmodule

// File: rtl/bsync_rx_ctrl.sv
module bsync_rx_ctrl
   import bsync_rx_pkg::*;
#(
   parameter int CHAR_MIN   = 5,
   parameter int CHAR_MAX   = 8,
   parameter int LEN_W      = 2,
   parameter int CNT_W      = 4,
   parameter bit HAS_PARITY = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bit_stb,
   input  logic                en_on,
   input  logic                en_rise,
   input  logic                din,
   input  logic [LEN_W-1:0]    len_code,
   input  logic                parity_en,
   input  logic                parity_odd,
   input  logic                dbl_syn,
   input  logic                strip_en,
   input  logic                ext_mode,
   input  logic                ext_rise,
   input  logic [CHAR_MAX-1:0] syn1,
   input  logic [CHAR_MAX-1:0] syn2,
   input  logic [CHAR_MAX-1:0] win_nxt,
   input  logic [CNT_W-1:0]    fill_nxt,
   output logic                ld,
   output logic [CHAR_MAX-1:0] ld_data,
   output logic                ld_perr,
   output logic                syn_set,
   output rx_state_e           st_q
);
   localparam int W      = CHAR_MAX;
   localparam int NCODES = 2 ** LEN_W;

   logic [W-1:0]     chr_tab  [NCODES];
   logic [W-1:0]     mask_tab [NCODES];
   logic [CNT_W-1:0] len_tab  [NCODES];

   // one extractor per length code; codes past CHAR_MAX fold onto CHAR_MAX
   for (genvar g = 0; g < NCODES; g++) begin : g_len
      localparam int LG = (CHAR_MIN + g > CHAR_MAX) ? CHAR_MAX : CHAR_MIN + g;
      assign chr_tab[g]  = W'(win_nxt[W-1 -: LG]);
      assign mask_tab[g] = {W{1'b1}} >> (W - LG);
      assign len_tab[g]  = CNT_W'(LG);
   end

   logic par_on;
   if (HAS_PARITY) begin : g_par
      assign par_on = parity_en;
   end else begin : g_nopar
      assign par_on = 1'b0;
   end

   logic [W-1:0]     chr, syn1_m, syn2_m, cand_q, fdata;
   logic [CNT_W-1:0] len_c, frm_c, cnt_q;
   logic             pskip_q, pend_q, prev1_q;
   logic             live, hunt_hit, frame_done, is1, is2, syn2_ok;

   assign chr    = chr_tab[len_code];
   assign syn1_m = syn1 & mask_tab[len_code];
   assign syn2_m = syn2 & mask_tab[len_code];
   assign len_c  = len_tab[len_code];
   assign frm_c  = len_c + CNT_W'(par_on);

   // a bit that is neither an external-sync start nor a skipped parity bit
   assign live       = bit_stb && !pend_q && !pskip_q;
   assign hunt_hit   = live && (st_q == ST_HUNT) && !ext_mode &&
                       (fill_nxt >= len_c) && (chr == syn1_m);
   assign frame_done = live && ((st_q == ST_SYN2) || (st_q == ST_SYNC)) &&
                       (cnt_q == frm_c - 1'b1);
   assign fdata      = par_on ? cand_q : chr;
   assign is1        = (fdata == syn1_m);
   assign is2        = (fdata == syn2_m);
   assign syn2_ok    = frame_done && (st_q == ST_SYN2) && is2;

   always_comb begin
      syn_set = (bit_stb && pend_q) || (hunt_hit && !dbl_syn) || syn2_ok;
      ld      = 1'b0;
      if (frame_done && (st_q == ST_SYNC)) begin
         if (!ext_mode) begin
            if (dbl_syn ? (prev1_q && is2) : is1) syn_set = 1'b1;
            ld = !(strip_en && (is1 || (dbl_syn && is2)));
         end else begin
            ld = 1'b1;
         end
      end
   end

   assign ld_data = fdata;
   assign ld_perr = par_on && (^fdata ^ din ^ parity_odd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cnt_q   <= '0;
         cand_q  <= '0;
         pskip_q <= 1'b0;
         pend_q  <= 1'b0;
         prev1_q <= 1'b0;
      end else if (!en_on) begin
         st_q    <= ST_IDLE;
         pskip_q <= 1'b0;
         pend_q  <= 1'b0;
      end else if (en_rise) begin
         st_q    <= ST_HUNT;
         cnt_q   <= '0;
         pskip_q <= 1'b0;
         pend_q  <= 1'b0;
         prev1_q <= 1'b0;
      end else begin
         if (bit_stb) begin
            if (pend_q) begin
               // this bit is data bit 0 of the first character
               st_q    <= ST_SYNC;
               cnt_q   <= CNT_W'(1);
               pend_q  <= 1'b0;
               pskip_q <= 1'b0;
               prev1_q <= 1'b0;
            end else if (pskip_q) begin
               pskip_q <= 1'b0;
            end else if (st_q == ST_HUNT) begin
               if (hunt_hit) begin
                  st_q    <= dbl_syn ? ST_SYN2 : ST_SYNC;
                  cnt_q   <= '0;
                  pskip_q <= par_on;
                  prev1_q <= 1'b0;
               end
            end else if (st_q != ST_IDLE) begin
               if (cnt_q == len_c - 1'b1) cand_q <= chr;
               if (frame_done) begin
                  cnt_q <= '0;
                  if (st_q == ST_SYN2) st_q <= syn2_ok ? ST_SYNC : ST_HUNT;
                  else                 prev1_q <= is1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end
         if (ext_mode && ext_rise) pend_q <= 1'b1;
      end
   end
endmodule

// File: rtl/bsync_rx_hold.sv
module bsync_rx_hold #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] ld_data,
   input  logic         ld_perr,
   input  logic         syn_set,
   input  logic         data_rd,
   input  logic         stat_rd,
   output logic [W-1:0] hold_data,
   output logic         rx_ready,
   output logic         parity_err,
   output logic         overrun_err,
   output logic         syn_det
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_data   <= '0;
         rx_ready    <= 1'b0;
         parity_err  <= 1'b0;
         overrun_err <= 1'b0;
         syn_det     <= 1'b0;
      end else begin
         if (ld) begin
            hold_data   <= ld_data;
            rx_ready    <= 1'b1;
            parity_err  <= ld_perr;
            overrun_err <= rx_ready && !data_rd;
         end else if (data_rd) begin
            rx_ready    <= 1'b0;
         end
         if (syn_set)      syn_det <= 1'b1;
         else if (stat_rd) syn_det <= 1'b0;
      end
   end
endmodule

// File: rtl/bsync_rx.sv
module bsync_rx
   import bsync_rx_pkg::*;
#(
   parameter int CHAR_MIN   = 5,
   parameter int CHAR_MAX   = 8,
   parameter int LEN_W      = 2,
   parameter bit HAS_PARITY = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_bit_en,
   input  logic                rx_data,
   input  logic                rx_enable,
   input  logic [CHAR_MAX-1:0] syn1,
   input  logic [CHAR_MAX-1:0] syn2,
   input  logic [LEN_W-1:0]    char_len,
   input  logic                parity_en,
   input  logic                parity_odd,
   input  logic                dbl_syn,
   input  logic                strip_en,
   input  logic                ext_mode,
   input  logic                ext_sync,
   input  logic                data_rd,
   input  logic                stat_rd,
   output logic [CHAR_MAX-1:0] hold_data,
   output logic                rx_ready,
   output logic                syn_det,
   output logic                parity_err,
   output logic                overrun_err
);
   localparam int CNT_W = $clog2(CHAR_MAX + 2);

   if (CHAR_MIN < 1 || CHAR_MIN > CHAR_MAX) begin : g_bad_len
      $error("bsync_rx: CHAR_MIN must lie in 1..CHAR_MAX");
   end
   if (CHAR_MAX - CHAR_MIN + 1 > 2 ** LEN_W) begin : g_bad_code
      $error("bsync_rx: LEN_W too narrow for the length range");
   end

   logic en_prev_q, ext_prev_q;
   logic en_rise, ext_rise, bit_stb;
   logic [CHAR_MAX-1:0] win_nxt, ld_data;
   logic [CNT_W-1:0]    fill_nxt;
   logic ld, ld_perr, syn_set;
   rx_state_e st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_prev_q  <= 1'b0;
         ext_prev_q <= 1'b0;
      end else begin
         en_prev_q  <= rx_enable;
         ext_prev_q <= ext_sync;
      end
   end

   assign en_rise  = rx_enable && !en_prev_q;
   assign ext_rise = ext_sync && !ext_prev_q;
   assign bit_stb  = rx_bit_en && rx_enable && en_prev_q;

   bsync_rx_shift #(.W(CHAR_MAX), .CNT_W(CNT_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (bit_stb),
      .clr      (en_rise),
      .din      (rx_data),
      .win_nxt  (win_nxt),
      .fill_nxt (fill_nxt)
   );

   bsync_rx_ctrl #(
      .CHAR_MIN(CHAR_MIN), .CHAR_MAX(CHAR_MAX), .LEN_W(LEN_W),
      .CNT_W(CNT_W), .HAS_PARITY(HAS_PARITY)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_stb    (bit_stb),
      .en_on      (rx_enable),
      .en_rise    (en_rise),
      .din        (rx_data),
      .len_code   (char_len),
      .parity_en  (parity_en),
      .parity_odd (parity_odd),
      .dbl_syn    (dbl_syn),
      .strip_en   (strip_en),
      .ext_mode   (ext_mode),
      .ext_rise   (ext_rise),
      .syn1       (syn1),
      .syn2       (syn2),
      .win_nxt    (win_nxt),
      .fill_nxt   (fill_nxt),
      .ld         (ld),
      .ld_data    (ld_data),
      .ld_perr    (ld_perr),
      .syn_set    (syn_set),
      .st_q       (st_q)
   );

   bsync_rx_hold #(.W(CHAR_MAX)) u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .ld          (ld),
      .ld_data     (ld_data),
      .ld_perr     (ld_perr),
      .syn_set     (syn_set),
      .data_rd     (data_rd),
      .stat_rd     (stat_rd),
      .hold_data   (hold_data),
      .rx_ready    (rx_ready),
      .parity_err  (parity_err),
      .overrun_err (overrun_err),
      .syn_det     (syn_det)
   );
endmodule

// File: rtl/bsync_rx_chk.sv
module bsync_rx_chk #(
   parameter int CHAR_MIN = 5,
   parameter int CHAR_MAX = 8,
   parameter int LEN_W    = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                rx_enable,
   input logic [LEN_W-1:0]    char_len,
   input logic                stat_rd,
   input logic [CHAR_MAX-1:0] hold_data,
   input logic                rx_ready,
   input logic                syn_det,
   input logic                overrun_err,
   input logic                ld,
   input logic                syn_set
);
   // R5: a load always leaves the holding register flagged full
   a_r5_ready_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> rx_ready);

   // R5: holding register changes only on a load
   a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(hold_data));

   // R5: unused upper bits of a freshly loaded character are zero
   a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rx_ready) && $stable(char_len)) |->
         ((hold_data >> (CHAR_MIN + int'(char_len))) == '0));

   // R2: nothing is loaded while the receiver is disabled
   a_r2_no_load_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_enable |-> !ld);

   // R10: the status bit rises only on a sync event
   a_r10_det_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(syn_det) |-> $past(syn_set));

   // R10: the status bit falls only after a status read
   a_r10_det_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(syn_det) |-> $past(stat_rd));

   // R7: an overrun can only follow a full holding register
   a_r7_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun_err) |-> $past(rx_ready));
endmodule

bind bsync_rx bsync_rx_chk #(
   .CHAR_MIN(CHAR_MIN), .CHAR_MAX(CHAR_MAX), .LEN_W(LEN_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_enable   (rx_enable),
   .char_len    (char_len),
   .stat_rd     (stat_rd),
   .hold_data   (hold_data),
   .rx_ready    (rx_ready),
   .syn_det     (syn_det),
   .overrun_err (overrun_err),
   .ld          (ld),
   .syn_set     (syn_set)
);

// File: tb/bsync_rx_bench.sv
`timescale 1ns/100ps
module bsync_rx_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_bit_en = 1'b0, rx_data = 1'b1, rx_enable = 1'b0;
   logic [7:0] syn1 = 8'h16, syn2 = 8'h7F;
   logic [1:0] char_len = 2'd3;
   logic       parity_en = 1'b0, parity_odd = 1'b0, dbl_syn = 1'b0;
   logic       strip_en = 1'b0, ext_mode = 1'b0, ext_sync = 1'b0;
   logic       data_rd = 1'b0, stat_rd = 1'b0;
   logic [7:0] hold_data;
   logic       rx_ready, syn_det, parity_err, overrun_err;

   int  n_chk = 0, n_fail = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   bsync_rx u_bsync_rx (
      .clk(clk), .rst_n(rst_n), .rx_bit_en(rx_bit_en), .rx_data(rx_data),
      .rx_enable(rx_enable), .syn1(syn1), .syn2(syn2), .char_len(char_len),
      .parity_en(parity_en), .parity_odd(parity_odd), .dbl_syn(dbl_syn),
      .strip_en(strip_en), .ext_mode(ext_mode), .ext_sync(ext_sync),
      .data_rd(data_rd), .stat_rd(stat_rd), .hold_data(hold_data),
      .rx_ready(rx_ready), .syn_det(syn_det), .parity_err(parity_err),
      .overrun_err(overrun_err)
   );

   // {len code[12:11], parity on[10], odd[9], corrupt parity[8], data[7:0]}
   localparam logic [12:0] VEC [8] = '{
      {2'd3, 1'b0, 1'b0, 1'b0, 8'hA5},
      {2'd0, 1'b0, 1'b0, 1'b0, 8'hFF},
      {2'd1, 1'b1, 1'b0, 1'b0, 8'h2D},
      {2'd2, 1'b1, 1'b1, 1'b0, 8'h5B},
      {2'd3, 1'b1, 1'b0, 1'b1, 8'hC3},
      {2'd3, 1'b1, 1'b1, 1'b1, 8'h81},
      {2'd0, 1'b1, 1'b1, 1'b0, 8'h0A},
      {2'd2, 1'b0, 1'b0, 1'b0, 8'h7E}
   };

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bit_tx(input logic b);
      @(negedge clk); rx_data = b; rx_bit_en = 1'b1;
      @(negedge clk); rx_bit_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic idle_tx(input int n);
      for (int i = 0; i < n; i++) bit_tx(1'b1);
   endtask

   task automatic char_tx(input logic [7:0] d, input int len,
                          input logic pe, input logic odd, input logic bad);
      logic [7:0] m;
      m = 8'((9'd1 << len) - 9'd1);
      for (int i = 0; i < len; i++) bit_tx(d[i]);
      if (pe) bit_tx((^(d & m)) ^ odd ^ bad);
   endtask

   task automatic hunt_start();
      @(negedge clk); rx_enable = 1'b0;
      @(negedge clk); @(negedge clk); rx_enable = 1'b1;
      @(negedge clk);
   endtask

   task automatic rd_data();
      @(negedge clk); data_rd = 1'b1; @(negedge clk); data_rd = 1'b0;
   endtask

   task automatic rd_stat();
      @(negedge clk); stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 hold_data", hold_data, 0);
      check("R1 rx_ready", rx_ready, 0);
      check("R1 syn_det", syn_det, 0);
      check("R1 errors", {parity_err, overrun_err}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // table walk: sync then one character per entry (R3 R5 R6 R11)
      for (int v = 0; v < 8; v++) begin
         int         len;
         logic [7:0] m, exp_d;
         len        = 5 + int'(VEC[v][12:11]);
         m          = 8'((9'd1 << len) - 9'd1);
         char_len   = VEC[v][12:11];
         parity_en  = VEC[v][10];
         parity_odd = VEC[v][9];
         dbl_syn    = 1'b0;
         strip_en   = 1'b0;
         syn1       = 8'h16 | (8'hE0 & ~m);   // R11: upper garbage
         exp_d      = VEC[v][7:0] & m;
         hunt_start();
         idle_tx(8);
         char_tx(8'h16, len, parity_en, parity_odd, 1'b0);
         check($sformatf("R3 R11 syn_det v%0d", v), syn_det, 1);
         check($sformatf("R3 sync char not loaded v%0d", v), rx_ready, 0);
         char_tx(VEC[v][7:0], len, parity_en, parity_odd, VEC[v][8]);
         check($sformatf("R5 rx_ready v%0d", v), rx_ready, 1);
         check($sformatf("R5 hold_data v%0d", v), hold_data, exp_d);
         check($sformatf("R6 parity_err v%0d", v), parity_err,
               VEC[v][8] & VEC[v][10]);
         rd_data();
         check($sformatf("R5 data_rd clears v%0d", v), rx_ready, 0);
         rd_stat();
         check($sformatf("R10 stat_rd clears v%0d", v), syn_det, 0);
      end

      char_len = 2'd3; parity_en = 1'b0; syn1 = 8'h16; syn2 = 8'h7F;

      // R2: receiver disabled ignores the stream
      @(negedge clk); rx_enable = 1'b0;
      idle_tx(8); char_tx(8'h16, 8, 1'b0, 1'b0, 1'b0);
      check("R2 disabled no sync", syn_det, 0);
      hunt_start(); idle_tx(8); char_tx(8'h16, 8, 1'b0, 1'b0, 1'b0);
      check("R2 rise starts hunt", syn_det, 1);
      rd_stat();
      hunt_start(); idle_tx(4); char_tx(8'hA5, 8, 1'b0, 1'b0, 1'b0);
      check("R2 re-enable hunts again", rx_ready, 0);
      check("R2 re-enable no sync", syn_det, 0);

      // R4: SYN1-SYN1-SYN2 must not synchronise
      dbl_syn = 1'b1;
      hunt_start(); idle_tx(8);
      char_tx(8'h16, 8, 1'b0, 1'b0, 1'b0);
      char_tx(8'h16, 8, 1'b0, 1'b0, 1'b0);
      char_tx(8'h7F, 8, 1'b0, 1'b0, 1'b0);
      idle_tx(16);
      check("R4 syn1 syn1 syn2 no sync", syn_det, 0);
      check("R4 syn1 syn1 syn2 no load", rx_ready, 0);
      // R4: correct pair synchronises
      hunt_start(); idle_tx(8);
      char_tx(8'h16, 8, 1'b0, 1'b0, 1'b0);
      char_tx(8'h7F, 8, 1'b0, 1'b0, 1'b0);
      check("R4 pair syn_det", syn_det, 1);
      check("R4 pair not loaded", rx_ready, 0);
      char_tx(8'h3C, 8, 1'b0, 1'b0, 1'b0);
      check("R4 first data", hold_data, 8'h3C);
      rd_data(); rd_stat();

      // R7 overrun
      dbl_syn = 1'b0;
      hunt_start(); idle_tx(8); char_tx(8'h16, 8, 1'b0, 1'b0, 1'b0);
      char_tx(8'h55, 8, 1'b0, 1'b0, 1'b0);
      check("R7 no overrun first", overrun_err, 0);
      char_tx(8'h33, 8, 1'b0, 1'b0, 1'b0);
      check("R7 overrun set", overrun_err, 1);
      check("R7 newest kept", hold_data, 8'h33);
      rd_data();
      char_tx(8'h0F, 8, 1'b0, 1'b0, 1'b0);
      check("R7 overrun cleared", overrun_err, 0);
      rd_data(); rd_stat();

      // R8 stripping
      strip_en = 1'b1;
      hunt_start(); idle_tx(8); char_tx(8'h16, 8, 1'b0, 1'b0, 1'b0);
      rd_stat();
      check("R10 cleared before strip", syn_det, 0);
      char_tx(8'h16, 8, 1'b0, 1'b0, 1'b0);
      check("R8 stripped not loaded", rx_ready, 0);
      check("R8 later syn sets syn_det", syn_det, 1);
      char_tx(8'h41, 8, 1'b0, 1'b0, 1'b0);
      check("R8 data after strip", hold_data, 8'h41);
      rd_data();
      strip_en = 1'b0;
      char_tx(8'h16, 8, 1'b0, 1'b0, 1'b0);
      check("R8 no strip loads syn", rx_ready, 1);
      check("R8 no strip value", hold_data, 8'h16);
      rd_data(); rd_stat();

      // R9 external sync
      ext_mode = 1'b1; strip_en = 1'b1;
      hunt_start(); idle_tx(8); char_tx(8'h16, 8, 1'b0, 1'b0, 1'b0); idle_tx(4);
      check("R9 pattern search off", syn_det, 0);
      check("R9 nothing loaded", rx_ready, 0);
      @(negedge clk); ext_sync = 1'b1;
      @(negedge clk); @(negedge clk); ext_sync = 1'b0;
      char_tx(8'h5A, 8, 1'b0, 1'b0, 1'b0);
      check("R9 framing from pulse", hold_data, 8'h5A);
      check("R9 ready", rx_ready, 1);
      check("R9 syn_det", syn_det, 1);
      rd_data();
      char_tx(8'h16, 8, 1'b0, 1'b0, 1'b0);
      check("R9 no compare in ext mode", hold_data, 8'h16);
      repeat (20) @(negedge clk);
      check("R10 syn_det held", syn_det, 1);
      rd_stat();
      check("R10 syn_det read clears", syn_det, 0);
      ext_mode = 1'b0; rd_data();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule